// File: doc/BRIEF.md
# Per-Slot Two-Bit Branch Predictor with Redirect Control

This block keeps a saturating two-bit counter for every instruction-memory slot of a five-stage in-order pipeline and produces the fetch redirect and pipeline-register flush controls that go with branch prediction. When a conditional branch sits in the decode stage, its slot index selects a counter. If that counter says "taken", the block loads the program counter with the target that decode computed and squashes the fetch/decode register. The prediction bit and the slot index travel down the pipeline with the branch and come back to this block when the branch reaches execute.

In execute, the real branch outcome from the comparator is checked against the prediction that was carried along. A correct guess drives the counter straight to its strong state. A wrong guess moves the counter one step toward the other side, flushes the fetch/decode and decode/execute registers, and steers the program counter to the target or to the fall-through address. An execute-stage correction always beats a decode-stage taken prediction in the same cycle. The comparator and the address adders are outside the block. Their results arrive as inputs.

Top module: `bpred_ctrl`

## Requirements
- R1: After reset every counter holds weakly-not-taken. Counter codes are 0 strongly not taken, 1 weakly not taken, 2 weakly taken and 3 strongly taken. The counter addressed by `id_idx` is always visible on `id_ctr`.
- R2: When `id_valid_br` is high, the addressed counter is 2 or 3 and there is no misprediction, `id_pred_taken`, `pc_load` and `flush_ifid` are high, `pc_value` equals `id_target`, and `flush_idex` is low.
- R3: With no branch in decode, or with a counter of 0 or 1 and no misprediction, `pc_load`, `flush_ifid`, `flush_idex` and `id_pred_taken` are all low.
- R4: A resolved branch whose outcome `ex_taken` equals `ex_pred_taken` sets its counter to 3 if taken and to 0 if not taken. It raises no flush or load of its own.
- R5: A resolved branch whose outcome differs from `ex_pred_taken` raises `pc_load`, `flush_ifid` and `flush_idex` in the same cycle. `pc_value` is `ex_target` when taken and `ex_pc4` when not taken.
- R6: On a misprediction the counter steps up by one when the branch was taken and down by one when it was not taken, saturating at 3 and at 0.
- R7: When a misprediction and a decode taken prediction occur in the same cycle, `pc_value` takes the execute-stage address and `flush_idex` is high.
- R8: Updates go to the entry named by `ex_idx` and become visible on `id_ctr` from the next cycle. A lookup of that entry in the same cycle sees the value it held before the update.
- R9: An index of `SLOTS` or above reads as 1 and is never written. Redirect and flush behaviour for such a branch is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| id_valid_br | input | 1 | A conditional branch is in the decode stage |
| id_idx | input | IDX_W | Slot index of the instruction in decode |
| id_target | input | ADDR_W | Branch target computed in decode |
| ex_valid_br | input | 1 | A conditional branch is resolving in execute |
| ex_idx | input | IDX_W | Slot index carried with the resolving branch |
| ex_pred_taken | input | 1 | Prediction bit carried with the resolving branch |
| ex_taken | input | 1 | Actual outcome from the comparator |
| ex_target | input | ADDR_W | Branch target carried in the decode/execute register |
| ex_pc4 | input | ADDR_W | Fall-through address carried in the decode/execute register |
| id_ctr | output | 2 | Counter value for `id_idx` |
| id_pred_taken | output | 1 | Prediction to store with the decode branch |
| pc_load | output | 1 | Load the program counter with `pc_value` |
| pc_value | output | ADDR_W | Redirect address |
| flush_ifid | output | 1 | Zero the fetch/decode register |
| flush_idex | output | 1 | Zero the decode/execute register |

## Verification
A full sweep of decode indices after reset shows that every entry, including the ones beyond the table, starts at 1. Directed sequences walk one entry through a correct not-taken resolution, a taken misprediction, a decode lookup during its own update, and a saturating step from the strong state. Each case separates "force to strong" from "step by one" and "old value" from "new value". A collision of a decode taken prediction with an execute misprediction, resolved with the fall-through address, shows which redirect source wins. Constrained random traffic over a narrow range of indices, with prediction bits that sometimes disagree with the table, then covers every counter transition and also shows that an update never reaches a neighbouring entry.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'd0;
  localparam ctr_t CTR_WNT = 2'd1;
  localparam ctr_t CTR_WT  = 2'd2;
  localparam ctr_t CTR_ST  = 2'd3;

  // Prediction carried by a counter: upper bit set means taken.
  function automatic logic ctr_says_taken(input ctr_t c);
    return c[1];
  endfunction

  // Next counter value once a branch has resolved.
  function automatic ctr_t ctr_resolve(input ctr_t cur, input logic pred, input logic taken);
    ctr_t nxt;
    if (pred == taken) begin
      nxt = taken ? CTR_ST : CTR_SNT;
    end else if (taken) begin
      nxt = (cur == CTR_ST) ? CTR_ST : ctr_t'(cur + 2'd1);
    end else begin
      nxt = (cur == CTR_SNT) ? CTR_SNT : ctr_t'(cur - 2'd1);
    end
    return nxt;
  endfunction

endpackage

// File: rtl/bpred_rst_sync.sv
module bpred_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage0_q;
  logic stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage0_q <= 1'b0;
      stage1_q <= 1'b0;
    end else begin
      stage0_q <= 1'b1;
      stage1_q <= stage0_q;
    end
  end

  assign rst_n_sync = stage1_q;

endmodule

// File: rtl/bpred_table.sv
module bpred_table
  import bpred_pkg::*;
#(
  parameter int SLOTS = 100,
  parameter int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rda_idx,
  output ctr_t             rda_ctr,
  input  logic [IDX_W-1:0] rdb_idx,
  output ctr_t             rdb_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  ctr_t             wr_ctr
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

  ctr_t       ent_q [SLOTS];
  ctr_t       ent_d [SLOTS];
  logic [SLOTS-1:0] ent_we;

  // Per-entry write enables; an index past the table matches nothing.
  for (genvar g = 0; g < SLOTS; g++) begin : g_we
    assign ent_we[g] = wr_en && (wr_idx == IDX_W'(g));
  end

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      ent_d[i] = ent_we[i] ? wr_ctr : ent_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        ent_q[i] <= CTR_WNT;
      end
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        ent_q[i] <= ent_d[i];
      end
    end
  end

  // Read ports return the registered (pre-update) value.
  always_comb begin
    rda_ctr = CTR_WNT;
    if (rda_idx <= LAST_IDX) rda_ctr = ent_q[rda_idx];
  end

  always_comb begin
    rdb_ctr = CTR_WNT;
    if (rdb_idx <= LAST_IDX) rdb_ctr = ent_q[rdb_idx];
  end

endmodule

// File: rtl/bpred_resolve.sv
module bpred_resolve
  import bpred_pkg::*;
#(
  parameter int SLOTS = 100,
  parameter int IDX_W = $clog2(SLOTS)
) (
  input  logic             ex_valid_br,
  input  logic [IDX_W-1:0] ex_idx,
  input  logic             ex_pred_taken,
  input  logic             ex_taken,
  input  ctr_t             cur_ctr,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output ctr_t             wr_ctr,
  output logic             mispredict
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

  always_comb begin
    mispredict = ex_valid_br && (ex_taken != ex_pred_taken);
    wr_en      = ex_valid_br && (ex_idx <= LAST_IDX);
    wr_idx     = ex_idx;
    wr_ctr     = ctr_resolve(cur_ctr, ex_pred_taken, ex_taken);
  end

endmodule

// File: rtl/bpred_redirect.sv
module bpred_redirect
  import bpred_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              id_valid_br,
  input  ctr_t              id_ctr,
  input  logic [ADDR_W-1:0] id_target,
  input  logic              mispredict,
  input  logic              ex_taken,
  input  logic [ADDR_W-1:0] ex_target,
  input  logic [ADDR_W-1:0] ex_pc4,
  output logic              id_pred_taken,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_value,
  output logic              flush_ifid,
  output logic              flush_idex
);

  logic              id_redirect;
  logic [ADDR_W-1:0] ex_fix_addr;

  always_comb begin
    id_pred_taken = id_valid_br && ctr_says_taken(id_ctr);
    id_redirect   = id_pred_taken && !mispredict;
    ex_fix_addr   = ex_taken ? ex_target : ex_pc4;

    // Execute-stage correction has priority over a decode-stage guess.
    pc_load    = mispredict || id_redirect;
    pc_value   = mispredict ? ex_fix_addr : id_target;
    flush_ifid = mispredict || id_redirect;
    flush_idex = mispredict;
  end

endmodule

// File: rtl/bpred_ctrl.sv
module bpred_ctrl
  import bpred_pkg::*;
#(
  parameter int SLOTS  = 100,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid_br,
  input  logic [IDX_W-1:0]  id_idx,
  input  logic [ADDR_W-1:0] id_target,
  input  logic              ex_valid_br,
  input  logic [IDX_W-1:0]  ex_idx,
  input  logic              ex_pred_taken,
  input  logic              ex_taken,
  input  logic [ADDR_W-1:0] ex_target,
  input  logic [ADDR_W-1:0] ex_pc4,
  output logic [1:0]        id_ctr,
  output logic              id_pred_taken,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_value,
  output logic              flush_ifid,
  output logic              flush_idex
);

  logic             rst_n_s;
  ctr_t             id_ctr_w;
  ctr_t             ex_ctr_w;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  ctr_t             wr_ctr;
  logic             mispredict;

  bpred_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  bpred_table #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .rda_idx (id_idx),
    .rda_ctr (id_ctr_w),
    .rdb_idx (ex_idx),
    .rdb_ctr (ex_ctr_w),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_ctr  (wr_ctr)
  );

  bpred_resolve #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_resolve (
    .ex_valid_br   (ex_valid_br),
    .ex_idx        (ex_idx),
    .ex_pred_taken (ex_pred_taken),
    .ex_taken      (ex_taken),
    .cur_ctr       (ex_ctr_w),
    .wr_en         (wr_en),
    .wr_idx        (wr_idx),
    .wr_ctr        (wr_ctr),
    .mispredict    (mispredict)
  );

  bpred_redirect #(.ADDR_W(ADDR_W)) u_redirect (
    .id_valid_br   (id_valid_br),
    .id_ctr        (id_ctr_w),
    .id_target     (id_target),
    .mispredict    (mispredict),
    .ex_taken      (ex_taken),
    .ex_target     (ex_target),
    .ex_pc4        (ex_pc4),
    .id_pred_taken (id_pred_taken),
    .pc_load       (pc_load),
    .pc_value      (pc_value),
    .flush_ifid    (flush_ifid),
    .flush_idex    (flush_idex)
  );

  assign id_ctr = id_ctr_w;

endmodule

// File: rtl/bpred_ctrl_chk.sv
module bpred_ctrl_chk #(
  parameter int SLOTS  = 100,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = $clog2(SLOTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              id_valid_br,
  input logic [IDX_W-1:0]  id_idx,
  input logic [ADDR_W-1:0] id_target,
  input logic              ex_valid_br,
  input logic [IDX_W-1:0]  ex_idx,
  input logic              ex_pred_taken,
  input logic              ex_taken,
  input logic [ADDR_W-1:0] ex_target,
  input logic [ADDR_W-1:0] ex_pc4,
  input logic [1:0]        id_ctr,
  input logic              id_pred_taken,
  input logic              pc_load,
  input logic [ADDR_W-1:0] pc_value,
  input logic              flush_ifid,
  input logic              flush_idex
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

  // R5
  mispredict_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid_br && (ex_taken != ex_pred_taken)) |->
      (pc_load && flush_ifid && flush_idex &&
       pc_value == (ex_taken ? ex_target : ex_pc4)));

  // R2
  taken_guess_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid_br && id_ctr[1] && !(ex_valid_br && (ex_taken != ex_pred_taken))) |->
      (id_pred_taken && pc_load && flush_ifid && !flush_idex && pc_value == id_target));

  // R3
  quiet_when_no_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(id_valid_br && id_ctr[1]) && !(ex_valid_br && (ex_taken != ex_pred_taken))) |->
      (!pc_load && !flush_ifid && !flush_idex && !id_pred_taken));

  // R4
  correct_forces_strong_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid_br && (ex_taken == ex_pred_taken) && ex_idx <= LAST_IDX) |=>
      ((id_idx != $past(ex_idx)) || (id_ctr == ($past(ex_taken) ? 2'd3 : 2'd0))));

  // R7
  ex_beats_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_idex) |-> (flush_ifid && pc_load));

endmodule

bind bpred_ctrl bpred_ctrl_chk #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n_s),
  .id_valid_br   (id_valid_br),
  .id_idx        (id_idx),
  .id_target     (id_target),
  .ex_valid_br   (ex_valid_br),
  .ex_idx        (ex_idx),
  .ex_pred_taken (ex_pred_taken),
  .ex_taken      (ex_taken),
  .ex_target     (ex_target),
  .ex_pc4        (ex_pc4),
  .id_ctr        (id_ctr),
  .id_pred_taken (id_pred_taken),
  .pc_load       (pc_load),
  .pc_value      (pc_value),
  .flush_ifid    (flush_ifid),
  .flush_idex    (flush_idex)
);

// File: tb/bpred_ctrl_bench.sv
module bpred_ctrl_bench;

  localparam int SLOTS  = 100;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = $clog2(SLOTS);
  localparam int SPAN   = 1 << IDX_W;

  logic              clk;
  logic              rst_n;
  logic              id_valid_br;
  logic [IDX_W-1:0]  id_idx;
  logic [ADDR_W-1:0] id_target;
  logic              ex_valid_br;
  logic [IDX_W-1:0]  ex_idx;
  logic              ex_pred_taken;
  logic              ex_taken;
  logic [ADDR_W-1:0] ex_target;
  logic [ADDR_W-1:0] ex_pc4;
  logic [1:0]        id_ctr;
  logic              id_pred_taken;
  logic              pc_load;
  logic [ADDR_W-1:0] pc_value;
  logic              flush_ifid;
  logic              flush_idex;

  int n_tests;
  int n_fail;
  int mdl [SPAN];

  bpred_ctrl #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_bpred_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .id_valid_br   (id_valid_br),
    .id_idx        (id_idx),
    .id_target     (id_target),
    .ex_valid_br   (ex_valid_br),
    .ex_idx        (ex_idx),
    .ex_pred_taken (ex_pred_taken),
    .ex_taken      (ex_taken),
    .ex_target     (ex_target),
    .ex_pc4        (ex_pc4),
    .id_ctr        (id_ctr),
    .id_pred_taken (id_pred_taken),
    .pc_load       (pc_load),
    .pc_value      (pc_value),
    .flush_ifid    (flush_ifid),
    .flush_idex    (flush_idex)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int next_ctr(input int cur, input logic pred, input logic tk);
    if (pred == tk) return tk ? 3 : 0;
    if (tk) return (cur == 3) ? 3 : cur + 1;
    return (cur == 0) ? 0 : cur - 1;
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, check combinational outputs,
  // then advance the model to what the next rising edge stores.
  task automatic step(input string req,
                      input logic iv, input int ii, input logic [31:0] it,
                      input logic ev, input int ei, input logic ep, input logic et,
                      input logic [31:0] etg, input logic [31:0] ep4);
    logic mis, take;
    logic [31:0] exp_pc;
    @(negedge clk);
    id_valid_br   = iv;
    id_idx        = IDX_W'(ii);
    id_target     = it;
    ex_valid_br   = ev;
    ex_idx        = IDX_W'(ei);
    ex_pred_taken = ep;
    ex_taken      = et;
    ex_target     = etg;
    ex_pc4        = ep4;
    #2;
    mis    = ev && (et != ep);
    take   = iv && (mdl[ii] >= 2);
    exp_pc = mis ? (et ? etg : ep4) : it;
    check({req, "/R8"}, "id_ctr", longint'(id_ctr), longint'(mdl[ii]));
    check({req, "/R2"}, "id_pred_taken", longint'(id_pred_taken), longint'(take));
    check({req, "/R3"}, "pc_load", longint'(pc_load), longint'(mis || take));
    check({req, "/R3"}, "flush_ifid", longint'(flush_ifid), longint'(mis || take));
    check({req, "/R5"}, "flush_idex", longint'(flush_idex), longint'(mis));
    if (mis || take) check({req, "/R7"}, "pc_value", longint'(pc_value), longint'(exp_pc));
    if (ev && ei < SLOTS) mdl[ei] = next_ctr(mdl[ei], ep, et);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    n_tests = 0;
    n_fail  = 0;
    for (int i = 0; i < SPAN; i++) mdl[i] = 1;
    id_valid_br = 0; id_idx = '0; id_target = '0;
    ex_valid_br = 0; ex_idx = '0; ex_pred_taken = 0; ex_taken = 0;
    ex_target = '0; ex_pc4 = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);

    // R1: every entry, plus the unused index range, reads weakly not taken
    for (int i = 0; i < SPAN; i++)
      step("R1", 1'b0, i, 32'h0, 1'b0, 0, 1'b0, 1'b0, 32'h0, 32'h0);

    // R4: correct not-taken resolution forces entry 5 to 0
    step("R4", 1'b0, 0, 32'h0, 1'b1, 5, 1'b0, 1'b0, 32'h100, 32'h18);
    step("R4", 1'b1, 5, 32'h40, 1'b0, 0, 1'b0, 1'b0, 32'h0, 32'h0);
    check("R4", "entry5", longint'(id_ctr), 0);

    // R5/R6: taken misprediction on entry 6, redirect to target, 1 -> 2
    step("R5", 1'b0, 0, 32'h0, 1'b1, 6, 1'b0, 1'b1, 32'h2C, 32'h1C);
    check("R5", "mis_pc", longint'(pc_value), 64'h2C);
    step("R6", 1'b0, 6, 32'h0, 1'b0, 0, 1'b0, 1'b0, 32'h0, 32'h0);
    check("R6", "entry6_up", longint'(id_ctr), 2);

    // R2: decode lookup of entry 6 predicts taken and redirects to id_target
    step("R2", 1'b1, 6, 32'h88, 1'b0, 0, 1'b0, 1'b0, 32'h0, 32'h0);
    check("R2", "id_pc", longint'(pc_value), 64'h88);

    // R8: lookup of entry 6 during its own correct-taken update sees 2, then 3
    step("R8", 1'b1, 6, 32'h90, 1'b1, 6, 1'b1, 1'b1, 32'h90, 32'h1C);
    check("R8", "same_cycle_old", longint'(id_ctr), 2);
    step("R4", 1'b0, 6, 32'h0, 1'b0, 0, 1'b0, 1'b0, 32'h0, 32'h0);
    check("R4", "entry6_strong", longint'(id_ctr), 3);

    // R7: decode taken guess on 6 collides with not-taken mispredict on 9
    step("R7", 1'b1, 6, 32'hAA0, 1'b1, 9, 1'b1, 1'b0, 32'hBB0, 32'h28);
    check("R7", "ex_wins_pc", longint'(pc_value), 64'h28);
    check("R7", "ex_wins_idex", longint'(flush_idex), 1);
    step("R6", 1'b0, 9, 32'h0, 1'b0, 0, 1'b0, 1'b0, 32'h0, 32'h0);
    check("R6", "entry9_down", longint'(id_ctr), 0);

    // R6: saturation at 3 (stale not-taken bit on a strong entry)
    step("R6", 1'b0, 0, 32'h0, 1'b1, 6, 1'b0, 1'b1, 32'h50, 32'h1C);
    step("R6", 1'b0, 6, 32'h0, 1'b0, 0, 1'b0, 1'b0, 32'h0, 32'h0);
    check("R6", "sat_high", longint'(id_ctr), 3);
    // R6: saturation at 0
    step("R6", 1'b0, 0, 32'h0, 1'b1, 9, 1'b1, 1'b0, 32'h50, 32'h2C);
    step("R6", 1'b0, 9, 32'h0, 1'b0, 0, 1'b0, 1'b0, 32'h0, 32'h0);
    check("R6", "sat_low", longint'(id_ctr), 0);

    // R9: index past the table still redirects but is never written
    step("R9", 1'b0, 0, 32'h0, 1'b1, 110, 1'b0, 1'b1, 32'h300, 32'h1BC);
    check("R9", "oor_pc", longint'(pc_value), 64'h300);
    step("R9", 1'b1, 110, 32'h0, 1'b0, 0, 1'b0, 1'b0, 32'h0, 32'h0);
    check("R9", "oor_read", longint'(id_ctr), 1);

    // Random traffic on a narrow index band, including past-table indices
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      int ii, ei;
      logic ep;
      ii = 94 + int'($urandom % 10);
      ei = 94 + int'($urandom % 10);
      ep = ($urandom % 4 == 0) ? 1'($urandom) : ((mdl[ei] >= 2) ? 1'b1 : 1'b0);
      step("RND", 1'($urandom), ii, $urandom, 1'($urandom), ei, ep, 1'($urandom),
           $urandom, $urandom);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule